// File: doc/BRIEF.md
# Infrared Transceiver Mode and Eye-Safety Controller

This block is the digital control inside a half-duplex infrared link transceiver. It takes the transmit data line, a combined shutdown/mode line and a digitised "light seen" flag from the receiver front end. From these it produces the LED drive enable, an active-low receive data line with its output enable, a latched receiver bandwidth flag and a shutdown flag. Time limits are given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Three timed functions run side by side. The first is an eye-safety guard that drops the LED drive when transmit data is held high for too long. The second is a shutdown timer that powers the receiver down after the shutdown line has stayed high for a long time. The third is a bandwidth selector that samples transmit data when the shutdown line falls, provided the preceding high pulse was long enough. All inputs are synchronous to the clock.

Top module: `irx_ctrl`

## Requirements
- R1: With sd low and txd high, led_drv is 1 until the guard cuts it (R2). With txd low, led_drv is 0.
- R2: Let LED_LIM be ceil(LED_MAX_NS x CLK_HZ / 1e9). If txd is sampled high on LED_LIM consecutive clock edges, led_drv goes to 0 after the last of those edges, even though txd is still high. It stays 0 until txd is sampled low. The next txd high phase starts a fresh count.
- R3: Let SD_LIM be ceil(SHDN_NS x CLK_HZ / 1e9). shdn goes to 1 after sd has been sampled high on SD_LIM+1 consecutive edges, and not earlier.
- R4: The first edge on which sd is sampled low after a high phase clears shdn. The bandwidth decision of R5/R6 takes effect on that same edge.
- R5: On an sd falling edge that follows a high phase of more than PW_LIM = ceil(PULSE_NS x CLK_HZ / 1e9) sampled edges, mode_fir takes the value txd has on that edge (1 = high-bandwidth, 0 = low-bandwidth).
- R6: An sd high phase of PW_LIM sampled edges or fewer leaves mode_fir unchanged. mode_fir changes on no other event.
- R7: After reset, mode_fir = 0, shdn = 0, rxd_oe = 1 and led_drv = 0.
- R8: With sd low and txd low, rxd_n = 0 while light = 1 and rxd_n = 1 while light = 0.
- R9: While sd is high, led_drv = 0. rxd_n = 1 with rxd_oe = 1 before shutdown, and rxd_oe = 0 once shdn = 1.
- R10: With sd low and txd high, rxd_n echoes the LED: it equals the inverse of led_drv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Transmit data, active high |
| sd | input | 1 | Shutdown / mode-select line, active high |
| light | input | 1 | Receiver front end detects light |
| led_drv | output | 1 | LED drive enable |
| rxd_n | output | 1 | Receive data, active low |
| rxd_oe | output | 1 | Output enable for rxd_n (0 = tri-stated) |
| mode_fir | output | 1 | 1 = high-bandwidth receiver, 0 = low-bandwidth |
| shdn | output | 1 | Shutdown active |

## Verification
A guard counter that is off by one shows on led_drv exactly one cycle early or late at the LED_LIM boundary. A stale guard latch shows as the LED staying dark on the next txd pulse. A wrong shutdown count shows at rxd_oe on the cycle after edge SD_LIM+1. A pulse-width compare that is off by one shows in mode_fir one cycle after sd falls, when the pulse is exactly PW_LIM or PW_LIM+1 edges long. Receive-path errors appear at rxd_n immediately, because the path is combinational from the inputs and the flags.

// File: rtl/irx_pkg.sv
package irx_pkg;

  typedef enum logic {
    BW_LOW  = 1'b0,
    BW_HIGH = 1'b1
  } bw_mode_e;

  // Conservative conversion: round up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned hz);
    longint unsigned prod;
    prod = ns * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/irx_run_timer.sv
// Counts consecutive edges on which 'level' is high, saturating at LIMIT.
module irx_run_timer #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level,
  output logic [W-1:0] count,
  output logic         at_limit
);
  localparam logic [W-1:0] LIM_W = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!level)     count <= '0;
    else if (!at_limit)  count <= count + 1'b1;
  end

  assign at_limit = (count == LIM_W);
endmodule

// File: rtl/irx_mode_latch.sv
module irx_mode_latch
  import irx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sd,
  input  logic txd,
  input  logic pulse_ok,
  output logic sd_fall,
  output logic mode_fir
);
  logic     sd_q;
  bw_mode_e mode_q;

  assign sd_fall = sd_q & ~sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q   <= 1'b0;
      mode_q <= BW_LOW;
    end else begin
      sd_q <= sd;
      if (sd_fall && pulse_ok)
        mode_q <= txd ? BW_HIGH : BW_LOW;
    end
  end

  assign mode_fir = (mode_q == BW_HIGH);
endmodule

// File: rtl/irx_rx_path.sv
module irx_rx_path (
  input  logic sd,
  input  logic txd,
  input  logic light,
  input  logic led_drv,
  input  logic shdn,
  output logic rxd_n,
  output logic rxd_oe
);
  always_comb begin
    if (sd)       rxd_n = 1'b1;
    else if (txd) rxd_n = ~led_drv;
    else          rxd_n = ~light;
  end

  assign rxd_oe = ~shdn;
endmodule

// File: rtl/irx_ctrl.sv
module irx_ctrl
  import irx_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 200_000_000,
  parameter longint unsigned LED_MAX_NS = 50_000,
  parameter longint unsigned SHDN_NS    = 400_000,
  parameter longint unsigned PULSE_NS   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  input  logic sd,
  input  logic light,
  output logic led_drv,
  output logic rxd_n,
  output logic rxd_oe,
  output logic mode_fir,
  output logic shdn
);
  localparam int unsigned LED_LIM = ns_to_cycles(LED_MAX_NS, CLK_HZ);
  localparam int unsigned SD_LIM  = ns_to_cycles(SHDN_NS, CLK_HZ);
  localparam int unsigned PW_LIM  = ns_to_cycles(PULSE_NS, CLK_HZ);
  localparam int unsigned SD_TOP  = SD_LIM + 1;
  localparam int unsigned LED_W   = $clog2(LED_LIM + 1);
  localparam int unsigned SD_W    = $clog2(SD_TOP + 1);

  logic [LED_W-1:0] led_cnt;
  logic             led_cut;
  logic [SD_W-1:0]  sd_cnt;
  logic             pulse_ok;
  logic             sd_fall;

  irx_run_timer #(.LIMIT(LED_LIM), .W(LED_W)) u_led_guard (
    .clk(clk), .rst_n(rst_n), .level(txd),
    .count(led_cnt), .at_limit(led_cut)
  );

  irx_run_timer #(.LIMIT(SD_TOP), .W(SD_W)) u_sd_timer (
    .clk(clk), .rst_n(rst_n), .level(sd),
    .count(sd_cnt), .at_limit(shdn)
  );

  assign pulse_ok = (sd_cnt > SD_W'(PW_LIM));

  irx_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .sd(sd), .txd(txd),
    .pulse_ok(pulse_ok), .sd_fall(sd_fall), .mode_fir(mode_fir)
  );

  assign led_drv = txd & ~sd & ~led_cut;

  irx_rx_path u_rx (
    .sd(sd), .txd(txd), .light(light), .led_drv(led_drv), .shdn(shdn),
    .rxd_n(rxd_n), .rxd_oe(rxd_oe)
  );
endmodule

// File: rtl/irx_ctrl_chk.sv
module irx_ctrl_chk #(
  parameter int unsigned LED_LIM = 4
) (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic sd,
  input logic light,
  input logic led_drv,
  input logic rxd_n,
  input logic rxd_oe,
  input logic mode_fir,
  input logic shdn,
  input logic sd_fall
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= 0;
    else if (!txd)             run_q <= 0;
    else if (run_q < LED_LIM)  run_q <= run_q + 1;
  end

  // R2
  led_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd && run_q >= LED_LIM) |-> !led_drv);

  // R9
  sd_led_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd |-> !led_drv);

  // R3
  shdn_needs_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn) |-> $past(sd));

  // R4
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall |=> !shdn);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_fall |=> $stable(mode_fir));

  // R8
  rx_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd && !txd) |-> (rxd_n == !light));

  // R9
  rx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd && rxd_oe) |-> rxd_n);
endmodule

bind irx_ctrl irx_ctrl_chk #(.LED_LIM(LED_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .sd(sd), .light(light),
  .led_drv(led_drv), .rxd_n(rxd_n), .rxd_oe(rxd_oe),
  .mode_fir(mode_fir), .shdn(shdn), .sd_fall(sd_fall)
);

// File: tb/tb_irx_ctrl.sv
`timescale 1ns/1ps
module tb_irx_ctrl;
  localparam int PER_NS  = 5;
  localparam int LED_NS  = 1000;
  localparam int SHD_NS  = 4000;
  localparam int PUL_NS  = 50;
  localparam int LED_LIM = LED_NS / PER_NS;
  localparam int SD_LIM  = SHD_NS / PER_NS;
  localparam int PW_LIM  = PUL_NS / PER_NS;

  logic clk = 0, rst_n = 0, txd = 0, sd = 0, light = 0;
  logic led_drv, rxd_n, rxd_oe, mode_fir, shdn;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irx_ctrl #(.CLK_HZ(200_000_000), .LED_MAX_NS(LED_NS),
             .SHDN_NS(SHD_NS), .PULSE_NS(PUL_NS)) dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .sd(sd), .light(light),
    .led_drv(led_drv), .rxd_n(rxd_n), .rxd_oe(rxd_oe),
    .mode_fir(mode_fir), .shdn(shdn));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    check("R7 mode", mode_fir, 1'b0);
    check("R7 shdn", shdn, 1'b0);
    check("R7 oe", rxd_oe, 1'b1);
    check("R7 led", led_drv, 1'b0);
  endtask

  task automatic t_led_guard;
    txd = 1; #0.5;
    check("R1 led on", led_drv, 1'b1);
    check("R10 echo on", rxd_n, 1'b0);
    tick(LED_LIM - 1);
    check("R2 led before limit", led_drv, 1'b1);
    tick(1);
    check("R2 led cut at limit", led_drv, 1'b0);
    check("R10 echo cut", rxd_n, 1'b1);
    tick(50);
    check("R2 led stays cut", led_drv, 1'b0);
    txd = 0; tick(1);
    check("R1 led off txd low", led_drv, 1'b0);
    txd = 1; #0.5;
    check("R2 rearm", led_drv, 1'b1);
    tick(3);
    txd = 0; tick(2);
  endtask

  task automatic t_rx;
    light = 1; #0.5;
    check("R8 light", rxd_n, 1'b0);
    light = 0; #0.5;
    check("R8 dark", rxd_n, 1'b1);
    tick(1);
  endtask

  task automatic sd_pulse(input int edges, input logic tx);
    sd = 1; txd = tx; tick(edges);
    sd = 0; tick(1);
    txd = 0; tick(2);
  endtask

  task automatic t_mode;
    sd_pulse(20, 1'b1);
    check("R5 fir latched", mode_fir, 1'b1);
    sd_pulse(PW_LIM, 1'b0);
    check("R6 short pulse ignored", mode_fir, 1'b1);
    sd_pulse(PW_LIM + 1, 1'b0);
    check("R5 sir latched at boundary", mode_fir, 1'b0);
    sd_pulse(PW_LIM + 1, 1'b1);
    check("R5 fir at boundary", mode_fir, 1'b1);
  endtask

  task automatic t_shutdown;
    sd = 1; txd = 0; light = 1; #0.5;
    check("R9 led off sd", led_drv, 1'b0);
    check("R9 rxd high sd", rxd_n, 1'b1);
    tick(SD_LIM);
    check("R3 not yet shdn", shdn, 1'b0);
    check("R9 oe before shdn", rxd_oe, 1'b1);
    tick(1);
    check("R3 shdn entered", shdn, 1'b1);
    check("R9 tristate", rxd_oe, 1'b0);
    sd = 0; tick(1);
    check("R4 shdn cleared", shdn, 1'b0);
    check("R4 mode same edge", mode_fir, 1'b0);
    check("R4 oe back", rxd_oe, 1'b1);
    light = 0; tick(1);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_rx();
    t_led_guard();
    t_mode();
    t_shutdown();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule